// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation miss by reading one page table entry from memory and turning it into either a fill for the translation buffer or a fault code. A miss request carries the virtual address and the identifier of the address space that owns the addressed region. A set of configuration inputs gives the table base, the table size as a power of two, and the entry layout. All three are captured together with the miss.

Two layouts are supported. The compact layout is a linear table of 8-byte entries, and the entry address depends only on the page number. The extended layout is a hashed table of 32-byte entries. In that layout both the index and a check tag mix in the address-space identifier, so translations from many address spaces can share one table. An extended entry carries its tag in the third 64-bit word and a software-owned fourth word, which the walker discards. The table is itself virtually mapped. If the walker's own read comes back with a translation error, the walk is abandoned and a nested fault is reported. The walker never retries on its own.

Top module: `hpw_walker`

## Requirements
- R1: In compact mode (cfg_long=0) the read address is cfg_base + vpn*8, where vpn = miss_va[60:12]. mem_req_beats is 1, and miss_rid has no effect on the address.
- R2: In extended mode (cfg_long=1) the read address is cfg_base + 32*((vpn XOR miss_rid) mod 2^cfg_size), and mem_req_beats is 4.
- R3: In extended mode the third returned word is compared with the expected tag {1'b0, miss_rid[23:0], low 39 bits of (vpn >> cfg_size)}. A mismatch in bits 62:0 gives res_fault=2 (tag miss).
- R4: If bit 63 (tag-invalid) of the third word is set, the result is res_fault=2 even when bits 62:0 match.
- R5: If bit 0 (present) of the first word is clear, the result is res_fault=1. In extended mode the tag checks take priority.
- R6: A valid entry gives res_fault=0, res_ppn = word0[49:12] and res_attr = word0[11:1]. res_aux is word1 in extended mode and 0 in compact mode.
- R7: The fourth extended word has no effect on the result, and no further memory request is issued once the result is presented.
- R8: A response with mem_rsp_err=1 ends the walk at once with res_fault=3 (nested fault). No further beats are expected.
- R9: Only one walk is in flight at a time. miss_ready is low from the accepting edge until the result is taken with res_ready.
- R10: The request address and beat count stay stable until mem_req_ready. The result stays stable until res_ready.
- R11: After reset miss_ready=1, mem_req_valid=0 and res_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base | input | 64 | Table base address, captured with a miss |
| cfg_size | input | 6 | log2 of the number of hashed entries |
| cfg_long | input | 1 | 0 = compact linear layout, 1 = extended hashed layout |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Walker can accept a miss |
| miss_va | input | 64 | Missing virtual address |
| miss_rid | input | 24 | Address-space identifier of the region |
| mem_req_valid | output | 1 | Table read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Entry address |
| mem_req_beats | output | 3 | Number of 64-bit beats requested |
| mem_rsp_valid | input | 1 | Response beat valid |
| mem_rsp_err | input | 1 | Table reference itself missed translation |
| mem_rsp_data | input | 64 | Response beat data |
| res_valid | output | 1 | Fill or fault available |
| res_ready | input | 1 | Translation buffer takes the result |
| res_fault | output | 2 | 0 fill, 1 not present, 2 tag miss, 3 nested |
| res_ppn | output | 38 | Physical page number |
| res_attr | output | 11 | Entry attributes |
| res_aux | output | 64 | Second extended word, 0 in compact mode |

## Verification
The hardest case to reach is the split between a tag that is wrong and a tag that is right but flagged invalid. Both need the bench to rebuild the hashed index and tag exactly, then place a deliberately altered tag word in the third beat. Each stimulus vector therefore names a tag variant (exact, one bit flipped, or invalid bit set), and the bench forms the word from its own model of the hash. A nested fault on a middle beat of a four-beat read and a second miss offered while the result is back-pressured are driven as directed sequences.

// File: rtl/hpw_pkg.sv
package hpw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE        = 2'd0,
    FLT_NOT_PRESENT = 2'd1,
    FLT_TAG_MISS    = 2'd2,
    FLT_NESTED      = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_DATA = 2'd2,
    ST_DONE = 2'd3
  } walk_state_e;
endpackage

// File: rtl/hpw_addr_gen.sv
module hpw_addr_gen #(
  parameter int VA_W        = 64,
  parameter int PAGE_SHIFT  = 12,
  parameter int REGION_BITS = 3,
  parameter int RID_W       = 24,
  parameter int SIZE_W      = 6
) (
  input  logic              fmt_long,
  input  logic [63:0]       base,
  input  logic [SIZE_W-1:0] size,
  input  logic [VA_W-1:0]   va,
  input  logic [RID_W-1:0]  rid,
  output logic [63:0]       addr,
  output logic [63:0]       tag,
  output logic [2:0]        beats
);
  localparam int VPN_W    = VA_W - REGION_BITS - PAGE_SHIFT;
  localparam int TAG_HI_W = 63 - RID_W;

  function automatic logic [VPN_W-1:0] page_number(input logic [VA_W-1:0] a);
    return a[VA_W-REGION_BITS-1:PAGE_SHIFT];
  endfunction

  function automatic logic [VPN_W-1:0] hash_index(input logic [VPN_W-1:0] v,
                                                  input logic [RID_W-1:0] r,
                                                  input logic [SIZE_W-1:0] s);
    logic [VPN_W-1:0] mask;
    mask = ~({VPN_W{1'b1}} << s);
    return (v ^ VPN_W'(r)) & mask;
  endfunction

  function automatic logic [63:0] make_tag(input logic [VPN_W-1:0] v,
                                           input logic [RID_W-1:0] r,
                                           input logic [SIZE_W-1:0] s);
    logic [VPN_W-1:0] hi;
    hi = v >> s;
    return {1'b0, r, TAG_HI_W'(hi)};
  endfunction

  logic [VPN_W-1:0] vpn;
  logic [VPN_W-1:0] idx;

  always_comb begin
    vpn   = page_number(va);
    idx   = hash_index(vpn, rid, size);
    tag   = make_tag(vpn, rid, size);
    addr  = fmt_long ? base + (64'(idx) << 5) : base + (64'(vpn) << 3);
    beats = fmt_long ? 3'd4 : 3'd1;
  end
endmodule

// File: rtl/hpw_entry_check.sv
module hpw_entry_check #(
  parameter int PA_W       = 50,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                       fmt_long,
  input  logic                       nested,
  input  logic [63:0]                w0,
  input  logic [63:0]                w1,
  input  logic [63:0]                w2,
  input  logic [63:0]                exp_tag,
  output logic [1:0]                 fault,
  output logic [PA_W-PAGE_SHIFT-1:0] ppn,
  output logic [PAGE_SHIFT-2:0]      attr,
  output logic [63:0]                aux
);
  import hpw_pkg::*;

  logic tag_invalid;
  logic tag_match;
  logic present;

  always_comb begin
    tag_invalid = w2[63];
    tag_match   = (w2[62:0] == exp_tag[62:0]);
    present     = w0[0];
    if (nested)                                   fault = FLT_NESTED;
    else if (fmt_long && (tag_invalid || !tag_match)) fault = FLT_TAG_MISS;
    else if (!present)                            fault = FLT_NOT_PRESENT;
    else                                          fault = FLT_NONE;
    ppn  = w0[PA_W-1:PAGE_SHIFT];
    attr = w0[PAGE_SHIFT-1:1];
    aux  = fmt_long ? w1 : 64'd0;
  end
endmodule

// File: rtl/hpw_walker.sv
module hpw_walker #(
  parameter int VA_W        = 64,
  parameter int PA_W        = 50,
  parameter int PAGE_SHIFT  = 12,
  parameter int REGION_BITS = 3,
  parameter int RID_W       = 24,
  parameter int SIZE_W      = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [63:0]                cfg_base,
  input  logic [SIZE_W-1:0]          cfg_size,
  input  logic                       cfg_long,
  input  logic                       miss_valid,
  output logic                       miss_ready,
  input  logic [VA_W-1:0]            miss_va,
  input  logic [RID_W-1:0]           miss_rid,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic [63:0]                mem_req_addr,
  output logic [2:0]                 mem_req_beats,
  input  logic                       mem_rsp_valid,
  input  logic                       mem_rsp_err,
  input  logic [63:0]                mem_rsp_data,
  output logic                       res_valid,
  input  logic                       res_ready,
  output logic [1:0]                 res_fault,
  output logic [PA_W-PAGE_SHIFT-1:0] res_ppn,
  output logic [PAGE_SHIFT-2:0]      res_attr,
  output logic [63:0]                res_aux
);
  import hpw_pkg::*;

  walk_state_e       state_q;
  logic [VA_W-1:0]   va_q;
  logic [RID_W-1:0]  rid_q;
  logic [63:0]       base_q;
  logic [SIZE_W-1:0] size_q;
  logic              long_q;
  logic [63:0]       w0_q, w1_q, w2_q;
  logic [1:0]        beat_q;
  logic              nested_q;
  logic [63:0]       exp_tag;

  // named internal events
  logic walk_start, beat_take, walk_abort, walk_last, walk_handoff;

  hpw_addr_gen #(
    .VA_W(VA_W), .PAGE_SHIFT(PAGE_SHIFT), .REGION_BITS(REGION_BITS),
    .RID_W(RID_W), .SIZE_W(SIZE_W)
  ) u_addr (
    .fmt_long(long_q), .base(base_q), .size(size_q), .va(va_q), .rid(rid_q),
    .addr(mem_req_addr), .tag(exp_tag), .beats(mem_req_beats)
  );

  hpw_entry_check #(.PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)) u_check (
    .fmt_long(long_q), .nested(nested_q), .w0(w0_q), .w1(w1_q), .w2(w2_q),
    .exp_tag(exp_tag), .fault(res_fault), .ppn(res_ppn), .attr(res_attr),
    .aux(res_aux)
  );

  assign miss_ready    = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_REQ);
  assign res_valid     = (state_q == ST_DONE);
  assign walk_start    = miss_valid && miss_ready;
  assign beat_take     = (state_q == ST_DATA) && mem_rsp_valid;
  assign walk_abort    = beat_take && mem_rsp_err;
  assign walk_last     = beat_take && !mem_rsp_err && ({1'b0, beat_q} == mem_req_beats - 3'd1);
  assign walk_handoff  = res_valid && res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      va_q     <= '0;
      rid_q    <= '0;
      base_q   <= '0;
      size_q   <= '0;
      long_q   <= 1'b0;
      w0_q     <= '0;
      w1_q     <= '0;
      w2_q     <= '0;
      beat_q   <= '0;
      nested_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (walk_start) begin
          va_q     <= miss_va;
          rid_q    <= miss_rid;
          base_q   <= cfg_base;
          size_q   <= cfg_size;
          long_q   <= cfg_long;
          beat_q   <= '0;
          nested_q <= 1'b0;
          state_q  <= ST_REQ;
        end
        ST_REQ: if (mem_req_ready) state_q <= ST_DATA;
        ST_DATA: if (beat_take) begin
          if (walk_abort) begin
            nested_q <= 1'b1;
            state_q  <= ST_DONE;
          end else begin
            // the fourth (software) word is never stored
            case (beat_q)
              2'd0:    w0_q <= mem_rsp_data;
              2'd1:    w1_q <= mem_rsp_data;
              2'd2:    w2_q <= mem_rsp_data;
              default: ;
            endcase
            beat_q <= beat_q + 2'd1;
            if (walk_last) state_q <= ST_DONE;
          end
        end
        ST_DONE: if (res_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r9_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> !miss_ready);
  a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!miss_ready && !walk_handoff) |=> !miss_ready);
  a_r10_req_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_beats)));
  a_r10_res_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_fault) && $stable(res_ppn) && $stable(res_aux)));
  a_r8_nested_fault: assert property (@(posedge clk) disable iff (!rst_n)
    walk_abort |=> (res_valid && res_fault == FLT_NESTED));
  a_r7_no_extra_req: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !mem_req_valid);
  a_r1_one_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !long_q) |-> (mem_req_beats == 3'd1));

  always_ff @(posedge clk) begin
    if (rst_n && mem_req_valid && long_q)
      a_r2_entry_align: assert (((mem_req_addr - base_q) & 64'h1F) == 64'd0);
  end
endmodule

// File: tb/hpw_walker_tb.sv
`timescale 1ns/1ps
module hpw_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cfg_base = '0;
  logic [5:0]  cfg_size = '0;
  logic        cfg_long = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [63:0] miss_va = '0;
  logic [23:0] miss_rid = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic [2:0]  mem_req_beats;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_err = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [1:0]  res_fault;
  logic [37:0] res_ppn;
  logic [10:0] res_attr;
  logic [63:0] res_aux;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  hpw_walker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_size(cfg_size),
    .cfg_long(cfg_long), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_va(miss_va), .miss_rid(miss_rid), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_req_beats(mem_req_beats), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_err(mem_rsp_err), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
    .res_ppn(res_ppn), .res_attr(res_attr), .res_aux(res_aux)
  );

  typedef struct packed {
    logic        lng;
    logic [5:0]  size;
    logic [63:0] base;
    logic [63:0] va;
    logic [23:0] rid;
    logic [63:0] w0;
    logic [63:0] w1;
    logic [63:0] w3;
    logic [1:0]  tmode;     // 0 exact tag, 1 bit flipped, 2 invalid bit set
    logic [2:0]  err_beat;  // 7 = no error
    logic [1:0]  exp_fault;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  64'h0000_0040_0000_0000, 64'h2000_0000_1234_5000, 24'hABCDEF,
      64'h0002_3456_7890_1A27, 64'h0, 64'h0, 2'd0, 3'd7, 2'd0},
    '{1'b0, 6'd0,  64'h0000_0040_0000_0000, 64'h2000_0000_1234_5000, 24'h123456,
      64'h0001_1111_2222_3F55, 64'h0, 64'h0, 2'd0, 3'd7, 2'd0},
    '{1'b0, 6'd0,  64'h0000_0040_0000_1000, 64'h0000_7FFF_0000_1000, 24'h000001,
      64'h0002_3456_7890_1A26, 64'h0, 64'h0, 2'd0, 3'd7, 2'd1},
    '{1'b0, 6'd0,  64'h0000_0040_0000_0000, 64'hE000_0000_0000_F000, 24'h000002,
      64'h0002_3456_7890_1A27, 64'h0, 64'h0, 2'd0, 3'd0, 2'd3},
    '{1'b1, 6'd10, 64'h0000_0080_0000_0000, 64'h6000_0000_ABCD_E000, 24'h5A5A5A,
      64'h0003_FFFF_F000_0E01, 64'hDEAD_BEEF_0000_0011, 64'h1111_2222_3333_4444, 2'd0, 3'd7, 2'd0},
    '{1'b1, 6'd10, 64'h0000_0080_0000_0000, 64'h6000_0000_ABCD_E000, 24'h5A5A5A,
      64'h0003_FFFF_F000_0E01, 64'hDEAD_BEEF_0000_0011, 64'hFFFF_0000_FFFF_0000, 2'd0, 3'd7, 2'd0},
    '{1'b1, 6'd10, 64'h0000_0080_0000_0000, 64'h6000_0000_ABCD_E000, 24'h5A5A5A,
      64'h0003_FFFF_F000_0E01, 64'h0, 64'h0, 2'd1, 3'd7, 2'd2},
    '{1'b1, 6'd10, 64'h0000_0080_0000_0000, 64'h6000_0000_ABCD_E000, 24'h5A5A5A,
      64'h0003_FFFF_F000_0E01, 64'h0, 64'h0, 2'd2, 3'd7, 2'd2},
    '{1'b1, 6'd16, 64'h0000_0100_0000_0000, 64'h4000_0123_4567_8000, 24'hC0FFEE,
      64'h0001_0000_0000_0200, 64'h0, 64'h0, 2'd0, 3'd7, 2'd1},
    '{1'b1, 6'd16, 64'h0000_0100_0000_0000, 64'h4000_0123_4567_8000, 24'hC0FFEE,
      64'h0001_0000_0000_0201, 64'h0, 64'h0, 2'd0, 3'd2, 2'd3},
    '{1'b1, 6'd0,  64'h0000_0200_0000_0000, 64'hA000_0000_0042_1000, 24'h777777,
      64'h0000_ABCD_0000_07FF, 64'h0000_0000_0000_00A5, 64'h0, 2'd0, 3'd7, 2'd0}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] m_vpn(input logic [63:0] va);
    return (va << 3) >> 15;
  endfunction

  function automatic logic [63:0] m_addr(input vec_t v);
    logic [63:0] p;
    p = m_vpn(v.va);
    if (!v.lng) return v.base + p * 64'd8;
    return v.base + ((p ^ 64'(v.rid)) % (64'd1 << v.size)) * 64'd32;
  endfunction

  function automatic logic [63:0] m_tag(input vec_t v);
    logic [63:0] hi;
    hi = m_vpn(v.va) / (64'd1 << v.size);
    return (64'(v.rid) << 39) | (hi & ((64'd1 << 39) - 64'd1));
  endfunction

  task automatic run_walk(input vec_t v, input int req_delay, input int res_delay);
    logic [63:0] w2, d, a0;
    string rq, fq;
    int nb;
    w2 = m_tag(v);
    if (v.tmode == 2'd1) w2 = w2 ^ 64'd1;
    if (v.tmode == 2'd2) w2 = w2 | (64'd1 << 63);
    rq = v.lng ? "R2" : "R1";
    case (v.exp_fault)
      2'd0: fq = "R6";
      2'd1: fq = "R5";
      2'd2: fq = (v.tmode == 2'd2) ? "R4" : "R3";
      default: fq = "R8";
    endcase
    @(negedge clk);
    cfg_long = v.lng; cfg_size = v.size; cfg_base = v.base;
    miss_va = v.va; miss_rid = v.rid; miss_valid = 1'b1;
    chk(miss_ready == 1'b1, "R9 idle ready", 64'(miss_ready), 64'd1);
    @(negedge clk);
    miss_valid = 1'b0;
    chk(mem_req_valid == 1'b1, rq, 64'(mem_req_valid), 64'd1);
    chk(mem_req_addr == m_addr(v), rq, mem_req_addr, m_addr(v));
    chk(mem_req_beats == (v.lng ? 3'd4 : 3'd1), rq, 64'(mem_req_beats), v.lng ? 64'd4 : 64'd1);
    chk(miss_ready == 1'b0, "R9 busy", 64'(miss_ready), 64'd0);
    a0 = mem_req_addr;
    for (int i = 0; i < req_delay; i++) begin
      @(negedge clk);
      chk(mem_req_valid && mem_req_addr == a0, "R10 req hold", mem_req_addr, a0);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    nb = v.lng ? 4 : 1;
    for (int b = 0; b < nb; b++) begin
      d = (b == 0) ? v.w0 : (b == 1) ? v.w1 : (b == 2) ? w2 : v.w3;
      mem_rsp_valid = 1'b1; mem_rsp_data = d; mem_rsp_err = (b == int'(v.err_beat));
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
      if (b == int'(v.err_beat)) break;
    end
    chk(res_valid == 1'b1, fq, 64'(res_valid), 64'd1);
    chk(mem_req_valid == 1'b0, "R7 no further request", 64'(mem_req_valid), 64'd0);
    chk(res_fault == v.exp_fault, fq, 64'(res_fault), 64'(v.exp_fault));
    if (v.exp_fault == 2'd0) begin
      chk(res_ppn == v.w0[49:12], "R6 ppn", 64'(res_ppn), 64'(v.w0[49:12]));
      chk(res_attr == v.w0[11:1], "R6 attr", 64'(res_attr), 64'(v.w0[11:1]));
      chk(res_aux == (v.lng ? v.w1 : 64'd0), "R6 aux", res_aux, v.lng ? v.w1 : 64'd0);
    end
    for (int i = 0; i < res_delay; i++) begin
      miss_valid = 1'b1; miss_va = 64'h0; miss_rid = 24'h0;
      @(negedge clk);
      chk(miss_ready == 1'b0, "R9 second miss held off", 64'(miss_ready), 64'd0);
      chk(res_valid && res_fault == v.exp_fault, "R10 result hold", 64'(res_fault), 64'(v.exp_fault));
    end
    miss_valid = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && miss_ready, "R9 released", {62'd0, res_valid, miss_ready}, 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(miss_ready == 1'b1, "R11 miss_ready", 64'(miss_ready), 64'd1);
    chk(mem_req_valid == 1'b0, "R11 mem_req_valid", 64'(mem_req_valid), 64'd0);
    chk(res_valid == 1'b0, "R11 res_valid", 64'(res_valid), 64'd0);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) run_walk(VECS[k], 0, 0);
    // directed: stalled memory request and stalled result with a competing miss
    run_walk(VECS[4], 3, 3);
    run_walk(VECS[7], 2, 2);
    run_walk(VECS[3], 1, 4);
    // R8 abort on the first beat of an extended read
    begin
      vec_t v;
      v = VECS[9];
      v.err_beat = 3'd0;
      run_walk(v, 0, 1);
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule